// File: doc/BRIEF.md
# Transport Packet Identifier Gate

This block sits on a byte-parallel MPEG transport stream and thins it out before the stream is buffered. Each incoming byte comes with a strobe, and the first byte of every 188-byte packet also carries a start flag. The block reads the 13-bit packet identifier from the packet header and looks it up in a table with one pass bit per identifier value, so any set of identifiers can be selected.

A selected packet leaves the block whole and unchanged. An unselected packet collapses to a single placeholder byte of 0xC7. Because every packet still leaves a trace, a later stage can regenerate a filler packet in each empty slot and keep the original packet spacing. Until the decision is known, the header bytes wait in a three-stage delay line. As a result, every output byte appears exactly three accepted input bytes after the byte it stands for.

A host loads the table through a simple address, data and write-enable port, normally while the gate is held in reset.

Top module: `tsPidGate`

## Requirements
- R1: While `rstN` is low, and after its release until a valid packet has entered, `outValid` stays low.
- R2: When the table bit for a packet's identifier is 1, all 188 bytes of the packet come out unchanged and in their original order.
- R3: When the table bit for a packet's identifier is 0, exactly one byte of value 0xC7 comes out in place of the whole packet.
- R4: The identifier is the low 5 bits of packet byte 1, taken as bits 12..8, followed by byte 2 as bits 7..0. The top 3 bits of byte 1 have no effect on the decision.
- R5: An output byte is strobed only on a clock edge that also accepts an input byte. A byte or placeholder that belongs to input byte number n (counting accepted bytes from 0; for a placeholder, the packet's first byte) comes out on the edge that accepts byte n+3. Idle cycles between input bytes do not change the output.
- R6: A byte that carries the start flag but is not 0x47 starts no packet. Bytes are then discarded until a start-flagged 0x47 arrives, and that byte begins a packet that is handled normally.
- R7: A byte without the start flag that arrives while no packet is open is discarded, even when its value is 0x47. This includes any byte after the 188th byte of a packet.
- R8: A start-flagged 0x47 in the middle of a packet begins a new packet. If the old packet was still in its first three bytes, it produces no output. If it was already being passed, only the bytes received before the restart come out.
- R9: A host write with `hostWe` high stores `hostFlag` as the table bit of identifier `hostAddr`, including while `rstN` is low. Packets that arrive later are decided by the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of the packet logic (the table is kept) |
| inByte | input | 8 | Incoming stream byte |
| inValid | input | 1 | `inByte` is accepted on this edge |
| inStart | input | 1 | Accepted byte is the first byte of a packet |
| hostWe | input | 1 | Writes `hostFlag` into the table at `hostAddr` |
| hostAddr | input | 13 | Identifier whose table bit is written |
| hostFlag | input | 1 | 1 passes the identifier, 0 drops it |
| outByte | output | 8 | Outgoing stream byte |
| outValid | output | 1 | `outByte` holds a byte for this cycle |

## Verification
Every output byte is due on the edge that accepts the third valid input byte after its own, and a placeholder is due on the edge of the dropped packet's fourth byte. Gaps in the input strobe shift this due edge, not the due byte count. The bench numbers each accepted input byte. Every expected output is queued together with the number of the input byte whose edge must release it. Outputs are sampled 1 ns after the rising edge and compared with both the byte and that number. Discard cases are checked by counting outputs across a segment that is preceded by three flush bytes, so that no earlier packet's tail can fall inside it.

// File: rtl/pidGatePkg.sv
package pidGatePkg;

  // control state: waiting for sync, collecting header, streaming body
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_HDR,
    ST_BODY
  } gateState_t;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic shift;     // an input byte is accepted this edge
    logic decide;    // the last header byte arrives: resolve pass/drop
    logic bodyKeep;  // the accepted body byte belongs to a passed packet
  } gateStrobe_t;

  // header bytes that wait in the delay line before the decision
  localparam int HOLD_BYTES = 3;

endpackage

// File: rtl/pidGateCtrl.sv
module pidGateCtrl
  import pidGatePkg::*;
#(
  parameter int         PKT_LEN   = 188,
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inStart,
  input  logic [7:0]  inByte,
  input  logic        flagHit,
  output gateStrobe_t strobe
);

  localparam int CNT_W = $clog2(PKT_LEN);

  gateState_t       state, stateNext;
  logic [CNT_W-1:0] byteIdx, byteIdxNext;
  logic             passReg, passNext;
  logic             isSync;

  assign isSync = (inByte == SYNC_BYTE);

  always_comb begin
    stateNext     = state;
    byteIdxNext   = byteIdx;
    passNext      = passReg;
    strobe        = '0;
    strobe.shift  = inValid;
    if (inValid) begin
      if (inStart) begin
        // any start flag reopens framing; a wrong value sends us hunting
        stateNext   = isSync ? ST_HDR : ST_HUNT;
        byteIdxNext = isSync ? CNT_W'(1) : '0;
      end else begin
        unique case (state)
          ST_HUNT: begin
            byteIdxNext = '0;
          end
          ST_HDR: begin
            byteIdxNext = byteIdx + 1'b1;
            if (byteIdx == CNT_W'(HOLD_BYTES - 1)) begin
              strobe.decide = 1'b1;
              passNext      = flagHit;
              stateNext     = ST_BODY;
            end
          end
          ST_BODY: begin
            strobe.bodyKeep = passReg;
            if (byteIdx == CNT_W'(PKT_LEN - 1)) begin
              stateNext   = ST_HUNT;
              byteIdxNext = '0;
            end else begin
              byteIdxNext = byteIdx + 1'b1;
            end
          end
          default: stateNext = ST_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      byteIdx <= '0;
      passReg <= 1'b0;
    end else begin
      state   <= stateNext;
      byteIdx <= byteIdxNext;
      passReg <= passNext;
    end
  end

  // R6
  bad_sync_hunt_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inStart && (inByte != SYNC_BYTE) |=> state == ST_HUNT);

  // R8
  body_index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BODY |-> (byteIdx >= CNT_W'(HOLD_BYTES)) && (byteIdx <= CNT_W'(PKT_LEN - 1)));

  // R2
  body_after_decide_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_BODY) |-> $past(strobe.decide));

endmodule

// File: rtl/pidGatePath.sv
module pidGatePath
  import pidGatePkg::*;
#(
  parameter int         PID_W     = 13,
  parameter logic [7:0] MARK_BYTE = 8'hC7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inByte,
  input  gateStrobe_t      strobe,
  input  logic             hostWe,
  input  logic [PID_W-1:0] hostAddr,
  input  logic             hostFlag,
  output logic             flagHit,
  output logic [7:0]       outByte,
  output logic             outValid
);

  localparam int WORD_W = 32;
  localparam int SEL_W  = $clog2(WORD_W);
  localparam int ROWS   = 1 << (PID_W - SEL_W);
  localparam int HI_W   = PID_W - 8;
  localparam int LAST   = HOLD_BYTES - 1;

  // pass table, packed as words of flags to keep the element count low
  logic [WORD_W-1:0] flagMem [ROWS];

  always_ff @(posedge clk) begin
    if (hostWe)
      flagMem[hostAddr[PID_W-1:SEL_W]][hostAddr[SEL_W-1:0]] <= hostFlag;
  end

  // header delay line: stage 0 newest, stage LAST oldest
  logic [7:0] lineData [HOLD_BYTES];
  logic       lineKeep [HOLD_BYTES];
  logic [7:0] dataNext [HOLD_BYTES];
  logic       keepNext [HOLD_BYTES];
  logic [PID_W-1:0] pidNow;

  // identifier from byte 1 (already in stage 0) and byte 2 (on the input)
  assign pidNow  = {lineData[0][HI_W-1:0], inByte};
  assign flagHit = flagMem[pidNow[PID_W-1:SEL_W]][pidNow[SEL_W-1:0]];

  always_comb begin
    dataNext[0] = inByte;
    keepNext[0] = strobe.bodyKeep | (strobe.decide & flagHit);
    for (int i = 1; i < HOLD_BYTES; i++) begin
      dataNext[i] = lineData[i-1];
      keepNext[i] = strobe.decide ? flagHit : lineKeep[i-1];
    end
    if (strobe.decide) begin
      // oldest held byte becomes the packet's head or its placeholder
      keepNext[LAST] = 1'b1;
      if (!flagHit) dataNext[LAST] = MARK_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HOLD_BYTES; i++) begin
        lineData[i] <= '0;
        lineKeep[i] <= 1'b0;
      end
      outByte  <= '0;
      outValid <= 1'b0;
    end else if (strobe.shift) begin
      for (int i = 0; i < HOLD_BYTES; i++) begin
        lineData[i] <= dataNext[i];
        lineKeep[i] <= keepNext[i];
      end
      outByte  <= lineData[LAST];
      outValid <= lineKeep[LAST];
    end else begin
      outValid <= 1'b0;
    end
  end

  // R3
  drop_marker_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide && !flagHit |=> lineKeep[LAST] && (lineData[LAST] == MARK_BYTE));

  // R2
  pass_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide && flagHit |=> lineKeep[LAST] && (lineData[LAST] == $past(lineData[LAST-1])));

  // R5
  out_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.shift));

  // R9
  table_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWe |=> flagMem[$past(hostAddr[PID_W-1:SEL_W])][$past(hostAddr[SEL_W-1:0])] == $past(hostFlag));

endmodule

// File: rtl/tsPidGate.sv
module tsPidGate
  import pidGatePkg::*;
#(
  parameter int         PKT_LEN   = 188,
  parameter int         PID_W     = 13,
  parameter logic [7:0] SYNC_BYTE = 8'h47,
  parameter logic [7:0] MARK_BYTE = 8'hC7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  input  logic             inStart,
  input  logic             hostWe,
  input  logic [PID_W-1:0] hostAddr,
  input  logic             hostFlag,
  output logic [7:0]       outByte,
  output logic             outValid
);

  gateStrobe_t strobe;
  logic        flagHit;

  pidGateCtrl #(
    .PKT_LEN  (PKT_LEN),
    .SYNC_BYTE(SYNC_BYTE)
  ) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inStart(inStart),
    .inByte (inByte),
    .flagHit(flagHit),
    .strobe (strobe)
  );

  pidGatePath #(
    .PID_W    (PID_W),
    .MARK_BYTE(MARK_BYTE)
  ) path (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .strobe  (strobe),
    .hostWe  (hostWe),
    .hostAddr(hostAddr),
    .hostFlag(hostFlag),
    .flagHit (flagHit),
    .outByte (outByte),
    .outValid(outValid)
  );

endmodule

// File: tb/tsPidGate_test.sv
`timescale 1ns/1ps
module tsPidGate_test;

  localparam int PKT_LEN = 188;
  localparam int PID_W   = 13;
  localparam int NPID    = 1 << PID_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [7:0]       inByte = '0;
  logic             inValid = 1'b0;
  logic             inStart = 1'b0;
  logic             hostWe = 1'b0;
  logic [PID_W-1:0] hostAddr = '0;
  logic             hostFlag = 1'b0;
  logic [7:0]       outByte;
  logic             outValid;

  tsPidGate #(.PKT_LEN(PKT_LEN), .PID_W(PID_W)) uut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid), .inStart(inStart),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostFlag(hostFlag),
    .outByte(outByte), .outValid(outValid)
  );

  always #2 clk = ~clk;

  int   nChecks = 0;
  int   nFails = 0;
  int   gIdx = 0;
  int   curIdx = 0;
  int   outCount = 0;
  int   snap = 0;
  bit   tableInv = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] expByte [$];
  int         expDue  [$];
  string      expReq  [$];
  logic [7:0] eb;
  int         ed;
  string      er;

  task automatic chk(bit ok, string req, int act, int exp, string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit flagOf(int pid, bit inv);
    return ((((pid ^ (pid >> 4)) & 1) != 0) ^ inv);
  endfunction

  function automatic logic [7:0] pktByte(int pid, int top, int seed, int k);
    if (k == 0) return 8'h47;
    if (k == 1) return {3'(top), 5'(pid >> 8)};
    if (k == 2) return 8'(pid);
    return 8'(seed + k * 13);
  endfunction

  function automatic int firstPid(bit want, bit inv);
    for (int p = 1; p < NPID; p++) if (flagOf(p, inv) == want) return p;
    return 0;
  endfunction

  task automatic sendByte(logic [7:0] b, bit st, bit gap);
    @(negedge clk);
    inValid = 1'b1; inByte = b; inStart = st; curIdx = gIdx; gIdx++;
    if (gap) begin
      @(negedge clk);
      inValid = 1'b0; inStart = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0; inStart = 1'b0;
    end
  endtask

  // three unflagged bytes release the tail of the delay line (R7: they are discarded)
  task automatic flush();
    repeat (3) sendByte(8'h00, 1'b0, 1'b0);
    idle(2);
  endtask

  task automatic loadTable(bit inv);
    for (int a = 0; a < NPID; a++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = PID_W'(a); hostFlag = flagOf(a, inv);
    end
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic sendPacket(int pid, int top, int len, bit gap, int seed, string req);
    int  base;
    bit  pass;
    base = gIdx;
    pass = flagOf(pid, tableInv);
    if (len >= 3) begin
      if (pass) begin
        for (int k = 0; k < len; k++) begin
          expByte.push_back(pktByte(pid, top, seed, k));
          expDue.push_back(base + k + 3);
          expReq.push_back(req);
        end
      end else begin
        expByte.push_back(8'hC7);
        expDue.push_back(base + 3);
        expReq.push_back(req);
      end
    end
    for (int k = 0; k < len; k++) sendByte(pktByte(pid, top, seed, k), k == 0, gap);
  endtask

  // monitor: sample 1 ns after the edge, compare byte and due edge
  always @(posedge clk) begin
    #1;
    if (rstN && outValid && !finished) begin
      outCount++;
      if (!inValid) begin
        chk(1'b0, "R5", 0, 1, "output strobe without accepted input");
      end else if (expByte.size() == 0) begin
        chk(1'b0, "R7", int'(outByte), -1, "output byte where none is due");
      end else begin
        eb = expByte.pop_front();
        ed = expDue.pop_front();
        er = expReq.pop_front();
        chk(outByte == eb, er, int'(outByte), int'(eb), "output byte value");
        chk(curIdx == ed, "R5", curIdx, ed, "input index releasing byte");
      end
    end
  end

  initial begin
    int pidPass;
    int pidDrop;
    rstN = 1'b0;
    idle(3);
    chk(outValid == 1'b0, "R1", int'(outValid), 0, "outValid during reset");
    // R9: table loaded while reset is held
    loadTable(1'b0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    chk(outValid == 1'b0, "R1", int'(outValid), 0, "outValid after release");

    // R7: unflagged sync values with no packet open
    snap = outCount;
    repeat (5) sendByte(8'h47, 1'b0, 1'b0);
    idle(3);
    chk(outCount == snap, "R7", outCount - snap, 0, "outputs from unframed bytes");

    // sweep of identifiers, header junk bits and strobe gaps (R2, R3, R4, R5)
    for (int p = 0; p < 20; p++) begin
      int pid;
      int top;
      pid = (p == 0) ? 0 : (p == 1) ? NPID - 1 : (p * 1237 + 5) % NPID;
      top = p % 8;
      if (top != 0) sendPacket(pid, top, PKT_LEN, (p % 3) == 1, p * 17, "R4");
      else if (flagOf(pid, 1'b0)) sendPacket(pid, top, PKT_LEN, (p % 3) == 1, p * 17, "R2");
      else sendPacket(pid, top, PKT_LEN, (p % 3) == 1, p * 17, "R3");
    end
    flush();

    pidPass = firstPid(1'b1, 1'b0);
    pidDrop = firstPid(1'b0, 1'b0);

    // R6: wrong sync under the start flag, then recovery
    snap = outCount;
    sendByte(8'h48, 1'b1, 1'b0);
    for (int k = 0; k < 40; k++) sendByte((k == 5) ? 8'h47 : 8'(k), 1'b0, 1'b0);
    idle(3);
    chk(outCount == snap, "R6", outCount - snap, 0, "outputs after bad sync");
    sendPacket(pidPass, 0, PKT_LEN, 1'b0, 3, "R6");

    // R8: restart inside a passed body, then inside a header
    sendPacket(pidPass, 1, 100, 1'b0, 9, "R8");
    sendPacket(pidDrop, 0, PKT_LEN, 1'b0, 11, "R8");
    flush();
    snap = outCount;
    sendPacket(pidPass, 0, 2, 1'b0, 1, "R8");
    sendByte(8'h00, 1'b1, 1'b0);
    idle(3);
    chk(outCount == snap, "R8", outCount - snap, 0, "outputs from aborted header");
    sendPacket(pidPass, 2, PKT_LEN, 1'b1, 5, "R8");
    flush();
    chk(expByte.size() == 0, "R5", expByte.size(), 0, "bytes still owed before reload");

    // R9: rewrite the whole table inverted under reset
    @(negedge clk);
    rstN = 1'b0;
    tableInv = 1'b1;
    loadTable(1'b1);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    sendPacket(pidPass, 0, PKT_LEN, 1'b0, 21, "R9");
    sendPacket(pidDrop, 0, PKT_LEN, 1'b1, 22, "R9");
    for (int p = 0; p < 4; p++) sendPacket((p * 2999 + 1) % NPID, p, PKT_LEN, 1'b0, p, "R9");
    flush();
    chk(expByte.size() == 0, "R5", expByte.size(), 0, "bytes still owed at end");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule